// File: doc/BRIEF.md
# Batched Field Inverter for GF(2^m)

This block returns the multiplicative inverses of a group of N nonzero elements of a binary extension field. It performs only one real field inversion for the whole group. Operands arrive one per handshake on an input stream. While they arrive, the block keeps each operand and a running product of all operands seen so far. When the group is complete, a small iterative inverter raises the full product to the power 2^m - 2. This gives the inverse of the product.

A backward sweep then recovers each inverse. At each step it multiplies the stored prefix product one position lower by the current running inverse. It then folds the operand at that position into the running inverse. The sweep finishes the inverses from the highest index down. They are held in a register array and emitted in arrival order on an output stream that honours backpressure. A user supplies N operands, drains N results, and may then start the next group. One field inversion plus about 3(N-1) multiplications replace N inversions.

Top module: `gf_batch_inv`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A group is exactly N input handshakes (in_valid and in_ready both high at a clock edge). From the cycle after the N-th handshake, in_ready stays 0 until the group's last output handshake.
- R3: For every nonzero operand a_i of a group, the i-th output b_i satisfies a_i * b_i = 1 in GF(2^M). Multiplication is carry-less modulo the polynomial x^M + POLY. The default is M = 8 with POLY = 0x1B, i.e. x^8 + x^4 + x^3 + x + 1. Bit k of a data word is the coefficient of x^k.
- R4: Outputs leave in the order their operands arrived: the first output belongs to the first accepted operand.
- R5: Each group produces exactly N output handshakes (out_valid and out_ready both high). In the cycle after the last one, out_valid is 0 and in_ready is 1.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value on the next cycle.
- R7: in_valid and in_data are ignored while in_ready is 0. They have no effect on any output value of the current group or of later groups.
- R8: A group that contains a zero operand yields unspecified values, but it still yields N outputs. The block then accepts a new group, and that group's results meet R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block accepts an operand this cycle |
| in_data | input | M | Field element to invert |
| out_valid | output | 1 | Inverse available |
| out_ready | input | 1 | Consumer takes the inverse this cycle |
| out_data | output | M | Inverse of the matching operand |

## Verification
A wrong prefix product or a wrong running inverse in the backward sweep does not stay local. It corrupts every inverse of the group at or below the faulty index. That corruption appears at the output port within one group, at the latest N + M + N cycles after the last operand. A fault in the inverter corrupts all N outputs at once. A slip in the index counter shows up as outputs paired with the wrong operand, and this is visible with distinct operands. It can also show up as a miscount of handshakes, which appears as in_ready rising early or late. Stalls on the output stream expose any output register that changes while it is held.

// File: rtl/gf_batch_inv_pkg.sv
`timescale 1ns/1ps
package gf_batch_inv_pkg;

   typedef enum logic [1:0] {
      BI_LOAD   = 2'd0,
      BI_INVERT = 2'd1,
      BI_BACK   = 2'd2,
      BI_EMIT   = 2'd3
   } bi_state_e;

endpackage

// File: rtl/gf_mul.sv
`timescale 1ns/1ps
// Combinational GF(2^M) multiplier, modulus x^M + POLY.
module gf_mul #(
   parameter int              M         = 8,
   parameter logic [M-1:0]    POLY      = 8'h1B,
   parameter bit              MSB_FIRST = 1'b1
) (
   input  logic [M-1:0] op_a,
   input  logic [M-1:0] op_b,
   output logic [M-1:0] prod
);

   if (M < 2) begin : g_bad_m
      $error("gf_mul: M must be at least 2");
   end

   if (MSB_FIRST) begin : g_msb
      // Horner form: shift-reduce accumulator, add op_a on set bits of op_b
      logic [M-1:0] acc [M+1];
      assign acc[0] = '0;
      for (genvar i = 0; i < M; i++) begin : g_stage
         logic [M-1:0] shifted;
         assign shifted    = {acc[i][M-2:0], 1'b0} ^ (acc[i][M-1] ? POLY : '0);
         assign acc[i+1]   = shifted ^ (op_b[M-1-i] ? op_a : '0);
      end
      assign prod = acc[M];
   end else begin : g_lsb
      // Shift op_a upward, accumulate on set bits of op_b
      logic [M-1:0] sh  [M];
      logic [M-1:0] acc [M+1];
      assign sh[0]  = op_a;
      assign acc[0] = '0;
      for (genvar i = 0; i < M; i++) begin : g_stage
         assign acc[i+1] = acc[i] ^ (op_b[i] ? sh[i] : '0);
         if (i < M - 1) begin : g_shift
            assign sh[i+1] = {sh[i][M-2:0], 1'b0} ^ (sh[i][M-1] ? POLY : '0);
         end
      end
      assign prod = acc[M];
   end

endmodule

// File: rtl/gf_inv.sv
`timescale 1ns/1ps
// Iterative inverter: x^(2^M-2) as the product of x^(2^k), k = 1..M-1.
module gf_inv #(
   parameter int           M         = 8,
   parameter logic [M-1:0] POLY      = 8'h1B,
   parameter bit           MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] operand,
   output logic         done,
   output logic [M-1:0] result
);

   localparam int CNT_W = $clog2(M) + 1;

   logic [M-1:0]     sq_q, acc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [M-1:0]     sq_src, sq_next, acc_next;

   assign sq_src = start ? operand : sq_q;

   gf_mul #(.M(M), .POLY(POLY), .MSB_FIRST(MSB_FIRST)) u_square (
      .op_a (sq_src),
      .op_b (sq_src),
      .prod (sq_next)
   );

   gf_mul #(.M(M), .POLY(POLY), .MSB_FIRST(MSB_FIRST)) u_accum (
      .op_a (acc_q),
      .op_b (sq_q),
      .prod (acc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq_q   <= '0;
         acc_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else if (start && !busy_q) begin
         sq_q   <= sq_next;
         acc_q  <= M'(1);
         cnt_q  <= CNT_W'(M - 1);
         busy_q <= 1'b1;
         done   <= 1'b0;
      end else if (busy_q) begin
         acc_q <= acc_next;
         sq_q  <= sq_next;
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end

   assign result = acc_q;

   // R3: completion is a single-cycle event
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: a run always ends in a completion pulse after the last step
   p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q == CNT_W'(1)) |=> (done && !busy_q));

endmodule

// File: rtl/gf_batch_inv.sv
`timescale 1ns/1ps
module gf_batch_inv
   import gf_batch_inv_pkg::*;
#(
   parameter int           M         = 8,
   parameter logic [M-1:0] POLY      = 8'h1B,
   parameter int           N         = 4,
   parameter bit           MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [M-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [M-1:0] out_data
);

   localparam int              IDX_W = (N > 1) ? $clog2(N) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   if (N < 2) begin : g_bad_n
      $error("gf_batch_inv: N must be at least 2");
   end
   if (M < 2) begin : g_bad_m
      $error("gf_batch_inv: M must be at least 2");
   end

   bi_state_e        state_q;
   logic [IDX_W-1:0] idx_q, prev_idx;
   logic [M-1:0]     opnd_q [N];
   logic [M-1:0]     pref_q [N];
   logic [M-1:0]     inv_q  [N];
   logic [M-1:0]     run_q;
   logic             inv_go_q;
   logic             inv_done;
   logic [M-1:0]     inv_res;
   logic [M-1:0]     share_y, share_p, run_next;

   assign prev_idx = idx_q - IDX_W'(1);

   // Shared multiplier: prefix product while loading, lower inverse while sweeping
   assign share_y = (state_q == BI_LOAD) ? in_data : run_q;

   gf_mul #(.M(M), .POLY(POLY), .MSB_FIRST(MSB_FIRST)) u_share_mul (
      .op_a (pref_q[prev_idx]),
      .op_b (share_y),
      .prod (share_p)
   );

   gf_mul #(.M(M), .POLY(POLY), .MSB_FIRST(MSB_FIRST)) u_run_mul (
      .op_a (run_q),
      .op_b (opnd_q[idx_q]),
      .prod (run_next)
   );

   gf_inv #(.M(M), .POLY(POLY), .MSB_FIRST(MSB_FIRST)) u_inv (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (inv_go_q),
      .operand (pref_q[LAST]),
      .done    (inv_done),
      .result  (inv_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= BI_LOAD;
         idx_q    <= '0;
         run_q    <= '0;
         inv_go_q <= 1'b0;
         for (int k = 0; k < N; k++) begin
            opnd_q[k] <= '0;
            pref_q[k] <= '0;
            inv_q[k]  <= '0;
         end
      end else begin
         inv_go_q <= 1'b0;
         unique case (state_q)
            BI_LOAD: begin
               if (in_valid) begin
                  opnd_q[idx_q] <= in_data;
                  pref_q[idx_q] <= (idx_q == '0) ? in_data : share_p;
                  if (idx_q == LAST) begin
                     state_q  <= BI_INVERT;
                     inv_go_q <= 1'b1;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            BI_INVERT: begin
               if (inv_done) begin
                  run_q   <= inv_res;
                  state_q <= BI_BACK;
               end
            end
            BI_BACK: begin
               inv_q[idx_q] <= share_p;
               run_q        <= run_next;
               if (idx_q == IDX_W'(1)) begin
                  inv_q[0] <= run_next;
                  idx_q    <= '0;
                  state_q  <= BI_EMIT;
               end else begin
                  idx_q <= prev_idx;
               end
            end
            BI_EMIT: begin
               if (out_ready) begin
                  if (idx_q == LAST) begin
                     idx_q   <= '0;
                     state_q <= BI_LOAD;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            default: state_q <= BI_LOAD;
         endcase
      end
   end

   assign in_ready  = (state_q == BI_LOAD);
   assign out_valid = (state_q == BI_EMIT);
   assign out_data  = inv_q[idx_q];

   // Checker-only multiplier for the inverter result
   logic [M-1:0] chk_p;
   gf_mul #(.M(M), .POLY(POLY), .MSB_FIRST(MSB_FIRST)) u_chk_mul (
      .op_a (inv_res),
      .op_b (pref_q[LAST]),
      .prod (chk_p)
   );

   // R3: the single inversion really inverts the full product
   p_inv_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_done && pref_q[LAST] != '0) |-> (chk_p == M'(1)));

   // R2: the N-th accepted operand closes the input side
   p_load_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && idx_q == LAST) |=> !in_ready);

   // R5: the last output handshake reopens the input side
   p_emit_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && idx_q == LAST) |=> (in_ready && !out_valid));

   // R6: a stalled output is held
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R2: inversion completion moves straight to the backward sweep
   p_sweep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BI_INVERT && inv_done) |=> (state_q == BI_BACK && !in_ready));

endmodule

// File: tb/gf_batch_inv_tb_top.sv
`timescale 1ns/1ps
module gf_batch_inv_tb_top;

   localparam int M = 8;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [M-1:0] in_data = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [M-1:0] out_data;

   int n_checks = 0;
   int n_fails  = 0;
   logic [M-1:0] ops  [N];
   logic [M-1:0] outs [N];

   always #2 clk = ~clk;

   gf_batch_inv #(.M(M), .POLY(8'h1B), .N(N)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   // Reference multiplication in GF(2^8), modulus x^8+x^4+x^3+x+1
   function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p, x;
      p = 8'h00;
      x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p ^= x;
         x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
      end
      return p;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [M-1:0] v);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = v;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
   endtask

   task automatic load_group(input bit junk);
      for (int i = 0; i < N; i++) push(ops[i]);
      check("R2 in_ready low after N operands", in_ready, 0);
      if (junk) begin
         // R7: offer junk while busy
         in_valid = 1'b1;
         in_data  = 8'h00;
         while (!out_valid) begin
            @(negedge clk);
            in_data = in_data + 8'h37;
            if (!out_valid) check("R2 in_ready stays low while busy", in_ready, 0);
         end
         in_valid = 1'b0;
      end
   endtask

   task automatic drain(input bit stall);
      for (int i = 0; i < N; i++) begin
         while (!out_valid) @(negedge clk);
         if (stall) begin
            logic [M-1:0] held;
            held = out_data;
            for (int s = 0; s < 3; s++) begin
               @(negedge clk);
               check("R6 out_valid held during stall", out_valid, 1);
               check("R6 out_data held during stall", out_data, held);
            end
         end
         outs[i]   = out_data;
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
      end
      check("R5 out_valid low after N outputs", out_valid, 0);
      check("R5 in_ready high after N outputs", in_ready, 1);
   endtask

   task automatic verify_products(input string tag);
      for (int i = 0; i < N; i++)
         check(tag, ref_mul(ops[i], outs[i]), 8'h01);
   endtask

   task automatic t_reset();
      check("R1 in_ready after reset", in_ready, 1);
      check("R1 out_valid after reset", out_valid, 0);
   endtask

   task automatic t_known();
      ops[0] = 8'h53; ops[1] = 8'h02; ops[2] = 8'h8E; ops[3] = 8'hF1;
      load_group(0);
      drain(0);
      check("R3 inverse of 0x53", outs[0], 8'hCA);
      check("R4 inverse of 0x02 in second slot", outs[1], 8'h8D);
      verify_products("R3 known group a*b==1");
   endtask

   task automatic t_ones();
      for (int i = 0; i < N; i++) ops[i] = 8'h01;
      load_group(0);
      drain(0);
      for (int i = 0; i < N; i++) check("R3 inverse of one", outs[i], 8'h01);
   endtask

   task automatic t_repeat();
      ops[0] = 8'hFF; ops[1] = 8'hFF; ops[2] = 8'h80; ops[3] = 8'hFF;
      load_group(0);
      drain(1);
      verify_products("R3 repeated operands a*b==1");
   endtask

   task automatic t_random(input int rounds);
      for (int r = 0; r < rounds; r++) begin
         for (int i = 0; i < N; i++) begin
            logic [M-1:0] v;
            v = M'($urandom_range(1, 255));
            // distinct operands so slot mix-ups cannot hide (R4)
            for (int j = 0; j < i; j++) if (ops[j] == v) v = v ^ 8'h5A;
            if (v == 8'h00) v = 8'h01;
            ops[i] = v;
         end
         load_group(r[0]);
         drain(r[1]);
         verify_products("R4 random group in order a*b==1");
      end
   endtask

   task automatic t_junk();
      ops[0] = 8'h11; ops[1] = 8'h22; ops[2] = 8'h33; ops[3] = 8'h44;
      load_group(1);
      drain(0);
      verify_products("R7 junk while busy ignored");
      ops[0] = 8'h05; ops[1] = 8'h06; ops[2] = 8'h07; ops[3] = 8'h08;
      load_group(0);
      drain(0);
      verify_products("R7 next group unaffected");
   endtask

   task automatic t_zero();
      ops[0] = 8'h21; ops[1] = 8'h00; ops[2] = 8'h93; ops[3] = 8'h47;
      load_group(0);
      drain(0);   // drain itself checks N outputs then reopen (R8)
      check("R8 accepts again after zero group", in_ready, 1);
      ops[0] = 8'h9C; ops[1] = 8'h3D; ops[2] = 8'hE2; ops[3] = 8'h6B;
      load_group(0);
      drain(1);
      verify_products("R8 group after zero group a*b==1");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_known();
      t_ones();
      t_repeat();
      t_junk();
      t_zero();
      t_random(24);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule